// File: doc/BRIEF.md
# Output Driver Impedance Calibration Stepper

This block keeps the impedance code that sets the strength of a chip's output drivers. An analog comparator outside this block decides whether the code should rise or fall, and passes that decision in on a two-bit compare input. A free-running timer opens an evaluation window once per period. At each window the controller samples the compare input and records at most one pending step. That step reaches the drivers only on a cycle in which the outputs are in high impedance, because changing a driver that is active would corrupt the data on the bus. Write cycles, deselected cycles and output-enable-high cycles all count as high impedance.

The step logic is a four-state machine. ST_IDLE means no step is waiting. ST_PEND_UP and ST_PEND_DN each hold one step that has not been applied yet. ST_FORCED is the minimum-impedance override.

The transitions are:
- evaluation load: an evaluation edge moves any non-forced state to ST_PEND_UP, ST_PEND_DN or ST_IDLE, according to the decision.
- hiz apply: a high-impedance edge moves a pending state back to ST_IDLE and steps the code.
- force entry: force_min taken high moves any state to ST_FORCED.
- force release: force_min taken low moves ST_FORCED back to ST_IDLE.

If a force entry and an evaluation fall on the same edge, the force entry wins.

A separate counter tallies the cycles that are not reads after reset. It raises a settled flag once the driver match may be trusted.

The legal range of the external reference maps onto a bounded code range from CODE_MIN to CODE_MAX.

Top module: `drv_imp_cal`

## Requirements
- R1: The compare input is sampled only at evaluation edges, which are the edges numbered EVAL_PERIOD, 2·EVAL_PERIOD and so on, counting from the first rising edge after reset release as edge 1. On every other edge cmp_dir has no effect on drv_code.
- R2: The compare encoding is 2'b01 step up (+1), 2'b10 step down (−1), and 2'b00 or 2'b11 hold. One evaluation changes the code by at most one step.
- R3: A pending step is applied only at an edge where hiz_now is 1. The new drv_code is visible in the cycle that follows. While hiz_now is 0 the code does not change.
- R4: A pending step waits through any number of driving cycles. A later evaluation replaces it, and a hold evaluation cancels it. Steps never accumulate.
- R5: The code saturates: a step up at CODE_MAX and a step down at CODE_MIN are both discarded. The defaults are 0 and 31 on a 5-bit code.
- R6: From the cycle after force_min is sampled high, drv_code reads CODE_MIN. While forced, any pending step and any evaluation are discarded. From the cycle after force_min is sampled low, the code held before the force is shown again.
- R7: cal_settled rises after exactly SETTLE_CYCLES edges with op_read low since reset. Edges with op_read high do not count. Once high, cal_settled stays high until reset.
- R8: Reset (active-low, asynchronous) sets drv_code to RESET_CODE (default 16), clears cal_settled and clears any pending step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_dir | input | 2 | Comparator decision: 01 up, 10 down, 00/11 hold |
| hiz_now | input | 1 | Outputs are high impedance this cycle |
| op_read | input | 1 | This cycle is a read |
| force_min | input | 1 | Force the minimum-impedance code |
| drv_code | output | CODE_W | Impedance code applied to the drivers |
| cal_settled | output | 1 | Enough non-read cycles have elapsed since reset |

## Verification
The bench builds the block with EVAL_PERIOD=8 and SETTLE_CYCLES=40, and keeps the default 5-bit code range and reset code 16. The short period lets the bench walk the code from 16 up to the 31 ceiling and then down to the 0 floor within a few hundred cycles. The reduced settle count lets it place the exact edge where cal_settled rises, with read cycles mixed in beforehand. Under these values, replacement of a pending step by a later evaluation and the ignoring of the compare input between windows both take only a few periods to reach.

// File: rtl/drv_imp_pkg.sv
package drv_imp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PEND_UP = 2'd1,
        ST_PEND_DN = 2'd2,
        ST_FORCED  = 2'd3
    } cal_state_t;

    localparam logic [1:0] CMP_STEP_UP = 2'b01;
    localparam logic [1:0] CMP_STEP_DN = 2'b10;

endpackage

// File: rtl/imp_eval_timer.sv
module imp_eval_timer #(
    parameter int PERIOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic eval_tick
);
    localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);
    localparam bit POW2 = ((PERIOD & (PERIOD - 1)) == 0);

    logic [TW-1:0] cnt_q;

    assign eval_tick = (cnt_q == LAST);

    generate
        if (POW2) begin : g_wrap
            // power-of-two period: the counter wraps by itself
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_q + TW'(1);
            end
        end else begin : g_cmp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         cnt_q <= '0;
                else if (eval_tick) cnt_q <= '0;
                else                cnt_q <= cnt_q + TW'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/imp_settle_counter.sv
module imp_settle_counter #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic settled
);
    localparam int SW = $clog2(LIMIT + 1);
    localparam logic [SW-1:0] LIMIT_C = SW'(LIMIT);

    logic [SW-1:0] cnt_q;

    assign settled = (cnt_q == LIMIT_C);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (count_en && !settled) cnt_q <= cnt_q + SW'(1);
    end
endmodule

// File: rtl/imp_step_fsm.sv
module imp_step_fsm
    import drv_imp_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int CODE_MIN   = 0,
    parameter int CODE_MAX   = 31,
    parameter int RESET_CODE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_tick,
    input  logic [1:0]        cmp_dir,
    input  logic              hiz_now,
    input  logic              force_min,
    output logic [CODE_W-1:0] drv_code
);
    localparam logic [CODE_W-1:0] MIN_C = CODE_W'(CODE_MIN);
    localparam logic [CODE_W-1:0] MAX_C = CODE_W'(CODE_MAX);
    localparam logic [CODE_W-1:0] RST_C = CODE_W'(RESET_CODE);

    cal_state_t        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    cal_state_t        decision;
    logic              can_up, can_dn;

    assign can_up = (code_q < MAX_C);
    assign can_dn = (code_q > MIN_C);

    // evaluation result, saturation checked against the current code
    always_comb begin
        if (cmp_dir == CMP_STEP_UP && can_up)      decision = ST_PEND_UP;
        else if (cmp_dir == CMP_STEP_DN && can_dn) decision = ST_PEND_DN;
        else                                       decision = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FORCED: begin
                if (!force_min) state_d = ST_IDLE;   // force release
            end
            ST_IDLE, ST_PEND_UP, ST_PEND_DN: begin
                if (force_min) begin
                    state_d = ST_FORCED;             // force entry
                end else begin
                    if (hiz_now) state_d = ST_IDLE;  // hiz apply
                    if (eval_tick) state_d = decision; // evaluation load
                end
            end
        endcase
    end

    // outputs: code register stepped only on high-impedance edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= RST_C;
        end else if (hiz_now && !force_min) begin
            unique case (state_q)
                ST_PEND_UP: if (can_up) code_q <= code_q + CODE_W'(1);
                ST_PEND_DN: if (can_dn) code_q <= code_q - CODE_W'(1);
                ST_IDLE, ST_FORCED: ;
            endcase
        end
    end

    assign drv_code = (state_q == ST_FORCED) ? MIN_C : code_q;
endmodule

// File: rtl/drv_imp_cal.sv
module drv_imp_cal #(
    parameter int CODE_W        = 5,
    parameter int CODE_MIN      = 0,
    parameter int CODE_MAX      = 31,
    parameter int RESET_CODE    = 16,
    parameter int EVAL_PERIOD   = 32,
    parameter int SETTLE_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmp_dir,
    input  logic              hiz_now,
    input  logic              op_read,
    input  logic              force_min,
    output logic [CODE_W-1:0] drv_code,
    output logic              cal_settled
);
    logic eval_tick;

    imp_eval_timer #(.PERIOD(EVAL_PERIOD)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_tick (eval_tick)
    );

    imp_step_fsm #(
        .CODE_W     (CODE_W),
        .CODE_MIN   (CODE_MIN),
        .CODE_MAX   (CODE_MAX),
        .RESET_CODE (RESET_CODE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_tick (eval_tick),
        .cmp_dir   (cmp_dir),
        .hiz_now   (hiz_now),
        .force_min (force_min),
        .drv_code  (drv_code)
    );

    imp_settle_counter #(.LIMIT(SETTLE_CYCLES)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (!op_read),
        .settled  (cal_settled)
    );
endmodule

// File: rtl/drv_imp_cal_chk.sv
module drv_imp_cal_chk #(
    parameter int CODE_W   = 5,
    parameter int CODE_MIN = 0,
    parameter int CODE_MAX = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hiz_now,
    input logic              op_read,
    input logic              force_min,
    input logic [CODE_W-1:0] drv_code,
    input logic              cal_settled
);
    // R3: without a high-impedance edge and away from force entry/release, the code holds
    p_hiz_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(hiz_now) && !$past(force_min) && !$past(force_min, 2)) |-> $stable(drv_code));

    // R2: a single edge moves the code by one step at most
    p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(force_min) && !$past(force_min, 2)) |->
        ((int'(drv_code) - int'($past(drv_code)) <= 1) &&
         (int'($past(drv_code)) - int'(drv_code) <= 1)));

    // R5: code never leaves its legal range
    p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(drv_code) >= CODE_MIN) && (int'(drv_code) <= CODE_MAX));

    // R6: a sampled force shows the minimum code next cycle
    p_force_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_min |=> (int'(drv_code) == CODE_MIN));

    // R7: settled is sticky
    p_settle_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_settled |=> cal_settled);

    // R7: settled rises only after a non-read edge
    p_settle_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_settled) |-> !$past(op_read));
endmodule

bind drv_imp_cal drv_imp_cal_chk #(
    .CODE_W   (CODE_W),
    .CODE_MIN (CODE_MIN),
    .CODE_MAX (CODE_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hiz_now     (hiz_now),
    .op_read     (op_read),
    .force_min   (force_min),
    .drv_code    (drv_code),
    .cal_settled (cal_settled)
);

// File: tb/drv_imp_cal_test.sv
`timescale 1ns/1ps
module drv_imp_cal_test;
    localparam int P = 8;
    localparam int S = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_dir = 2'b00;
    logic       hiz_now = 1'b0;
    logic       op_read = 1'b0;
    logic       force_min = 1'b0;
    logic [4:0] drv_code;
    logic       cal_settled;

    int checks = 0;
    int fails = 0;
    int edges = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    drv_imp_cal #(.EVAL_PERIOD(P), .SETTLE_CYCLES(S)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_dir     (cmp_dir),
        .hiz_now     (hiz_now),
        .op_read     (op_read),
        .force_min   (force_min),
        .drv_code    (drv_code),
        .cal_settled (cal_settled)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // runs up to the next evaluation edge, offering d there and 00 elsewhere
    task automatic do_eval(input logic [1:0] d);
        while (((edges + 1) % P) != 0) cyc();
        cmp_dir = d;
        cyc();
        cmp_dir = 2'b00;
    endtask

    task automatic t_reset_and_settle();
        rst_n = 1'b0; cmp_dir = 2'b00; hiz_now = 1'b0; op_read = 1'b0; force_min = 1'b0;
        repeat (3) cyc();
        chk("R8 reset code", drv_code, 16);
        chk("R8 reset settled", cal_settled, 0);
        rst_n = 1'b1;
        op_read = 1'b1;
        repeat (20) cyc();
        chk("R7 reads do not count", cal_settled, 0);
        op_read = 1'b0;
        repeat (S - 1) cyc();
        chk("R7 one edge short", cal_settled, 0);
        cyc();
        chk("R7 settled at limit", cal_settled, 1);
        op_read = 1'b1;
        repeat (5) cyc();
        chk("R7 settled sticky", cal_settled, 1);
        op_read = 1'b0;
        chk("R8 code unchanged by hold evaluations", drv_code, 16);
    endtask

    task automatic t_held_until_hiz();
        hiz_now = 1'b0;
        do_eval(2'b01);
        repeat (3) cyc();
        chk("R3 step held while driving", drv_code, 16);
        hiz_now = 1'b1;
        cyc();
        chk("R3 step applied on hiz edge", drv_code, 17);
        hiz_now = 1'b0;
        repeat (2) cyc();
        chk("R3 single application", drv_code, 17);
    endtask

    task automatic t_down_timing();
        hiz_now = 1'b1;
        do_eval(2'b10);
        chk("R3 not yet applied at evaluation edge", drv_code, 17);
        cyc();
        chk("R2 step down applied", drv_code, 16);
        hiz_now = 1'b0;
    endtask

    task automatic t_replace();
        hiz_now = 1'b0;
        do_eval(2'b01);
        do_eval(2'b10);
        hiz_now = 1'b1; cyc(); hiz_now = 1'b0;
        chk("R4 later evaluation replaces pending", drv_code, 15);
        do_eval(2'b01);
        do_eval(2'b00);
        hiz_now = 1'b1; cyc(); hiz_now = 1'b0;
        chk("R4 hold evaluation cancels pending", drv_code, 15);
        do_eval(2'b01);
        do_eval(2'b11);
        hiz_now = 1'b1; cyc(); hiz_now = 1'b0;
        chk("R2 code 11 acts as hold", drv_code, 15);
    endtask

    task automatic t_ignore_between();
        hiz_now = 1'b1;
        cmp_dir = 2'b01;
        while (((edges + 1) % P) != 0) cyc();
        cmp_dir = 2'b00;
        cyc();
        cmp_dir = 2'b10;
        repeat (P - 2) cyc();
        cmp_dir = 2'b00;
        repeat (2) cyc();
        chk("R1 compare ignored off evaluation edges", drv_code, 15);
        hiz_now = 1'b0;
    endtask

    task automatic t_saturate();
        int exp = 15;
        hiz_now = 1'b1;
        for (int i = 0; i < 20; i++) begin
            do_eval(2'b01);
            cyc();
            exp = (exp < 31) ? exp + 1 : 31;
            chk("R5 climb with ceiling", drv_code, exp);
        end
        chk("R5 held at 31", drv_code, 31);
        for (int i = 0; i < 34; i++) begin
            do_eval(2'b10);
            cyc();
            exp = (exp > 0) ? exp - 1 : 0;
        end
        chk("R5 held at 0", drv_code, 0);
        for (int i = 0; i < 3; i++) begin
            do_eval(2'b01);
            cyc();
        end
        chk("R5 leaves floor", drv_code, 3);
    endtask

    task automatic t_force();
        hiz_now = 1'b1;
        force_min = 1'b1;
        cyc();
        chk("R6 forced to minimum", drv_code, 0);
        do_eval(2'b01);
        cyc();
        chk("R6 evaluation ignored while forced", drv_code, 0);
        force_min = 1'b0;
        cyc();
        chk("R6 release restores held code", drv_code, 3);
        hiz_now = 1'b0;
        do_eval(2'b10);
        force_min = 1'b1; cyc(); force_min = 1'b0; cyc();
        hiz_now = 1'b1;
        repeat (3) cyc();
        chk("R6 pending discarded by force", drv_code, 3);
        hiz_now = 1'b0;
    endtask

    initial begin
        t_reset_and_settle();
        t_held_until_hiz();
        t_down_timing();
        t_replace();
        t_ignore_between();
        t_saturate();
        t_force();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule